// File: doc/BRIEF.md
# Converter Cycle Sequencer with Serial Readout

This block runs a delta-sigma converter through its repeating cycle: a fixed-length conversion, an optional sleep, and a serial shift-out of the 32-bit result. It runs on the converter's oscillator clock. After power-up it waits out a reset interval measured in oscillator cycles before the first conversion starts. A brown-out input re-enters that interval at any time.

A host pulls the active-low select low to read the result. The word leaves MSB first. The serial clock comes from one of two sources: the block divides its oscillator by eight in internal-clock mode, or the host drives the clock in external-clock mode. Each conversion result is delivered once. When readout ends, or the host aborts it by raising select, the next conversion starts at once. The result word comes from a stubbed modulator and is captured on the last cycle of each conversion.

Top module: `conv_seq_top`

## Requirements
- R1: After `rst_ni` is released, or after a one-cycle `brownout_i` pulse, `eoc_o` stays low for `POR_CYCLES` oscillator cycles. It then stays low for one full conversion, so it first rises `POR_CYCLES` plus the conversion length cycles after the event.
- R2: A conversion lasts `CONV_1X` oscillator cycles when `speed_2x_i` is 0 and `CONV_2X` cycles when it is 1. The mode is captured when the conversion starts.
- R3: When a conversion ends with `cs_ni` high, the block sleeps. It keeps `eoc_o` high and `sdo_o` high for as long as `cs_ni` stays high.
- R4: During readout, `sdo_o` presents the word captured from `res_word_i` at the end of the conversion, MSB first, one bit per serial clock. The bit changes only after a falling serial clock edge, so it is valid at each rising edge.
- R5: With `sck_int_i` = 1, `sck_o` runs only during readout. It starts low and has a period of 8 oscillator cycles, low for the first half. It gives exactly 32 rising edges. At all other times `sck_o` is 0.
- R6: After the 32nd falling serial clock edge, readout ends and a new conversion starts, whatever the level of `cs_ni`. `eoc_o` drops in the same cycle.
- R7: If `cs_ni` goes high during readout, readout aborts on the next clock. `eoc_o` drops, a new conversion starts at once, and the next readout returns the new result.
- R8: While `eoc_o` is low, `sdo_o` is high. If `cs_ni` is already low when a conversion ends, readout starts directly without a sleep.
- R9: While `rst_ni` is low: `eoc_o` = 0, `sdo_o` = 1, `sck_o` = 0.
- R10: With `sck_int_i` = 0, each falling edge of `sck_i` shifts the word by one bit, and 32 falling edges end the readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| brownout_i | input | 1 | Supply-low indication; restarts the power-on interval |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | External serial clock, synchronous to `clk_i` |
| sck_int_i | input | 1 | 1: internal serial clock, 0: external |
| speed_2x_i | input | 1 | 1: short conversion, 0: long conversion |
| res_word_i | input | 32 | Result word from the modulator stub |
| eoc_o | output | 1 | High while an unread result is held |
| sdo_o | output | 1 | Serial data, MSB first |
| sck_o | output | 1 | Internal serial clock output |

## Verification
The bench builds the block with conversion lengths of 37 and 19 cycles and a 20-cycle power-on interval. These short, odd counts put both speed modes, the power-on and brown-out restarts, and dozens of complete cycles within a few thousand clocks. At this scale every conversion and reset length can be counted exactly, edge by edge. Readout is exercised with both serial clock sources, with an abort after five bits, and with select held low through a conversion.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_OUT   = 2'd2
  } seq_st_e;
endpackage

// File: rtl/conv_seq_por.sv
module conv_seq_por #(
  parameter int unsigned POR_CYCLES = 1229
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic brownout_i,
  output logic busy_o
);
  localparam int unsigned PW = $clog2(POR_CYCLES + 1);
  logic [PW-1:0] cnt_q;

  assign busy_o = cnt_q < PW'(POR_CYCLES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (brownout_i) cnt_q <= '0;
    else if (busy_o)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/conv_seq_sckgen.sv
module conv_seq_sckgen #(
  parameter int unsigned SCK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic int_mode_i,
  input  logic sck_i,
  output logic sck_o,
  output logic fall_o
);
  localparam int unsigned DW = $clog2(SCK_DIV);
  logic [DW-1:0] div_q;
  logic          ext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ext_q <= 1'b0;
    end else begin
      ext_q <= sck_i;
      if (!active_i || div_q == DW'(SCK_DIV - 1)) div_q <= '0;
      else                                        div_q <= div_q + 1'b1;
    end
  end

  // low half first, falling edge when the divider wraps
  assign sck_o  = active_i & int_mode_i & (div_q >= DW'(SCK_DIV / 2));
  assign fall_o = active_i & (int_mode_i ? (div_q == DW'(SCK_DIV - 1))
                                         : (ext_q & ~sck_i));
endmodule

// File: rtl/conv_seq_shift.sv
module conv_seq_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  assign msb_o = sh_q[WORD_W-1];
endmodule

// File: rtl/conv_seq_top.sv
module conv_seq_top
  import conv_seq_pkg::*;
#(
  parameter int unsigned CONV_1X    = 41036,
  parameter int unsigned CONV_2X    = 20556,
  parameter int unsigned POR_CYCLES = 1229,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned SCK_DIV    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              brownout_i,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              sck_int_i,
  input  logic              speed_2x_i,
  input  logic [WORD_W-1:0] res_word_i,
  output logic              eoc_o,
  output logic              sdo_o,
  output logic              sck_o
);
  localparam int unsigned CNT_MAX = (CONV_1X > CONV_2X) ? CONV_1X : CONV_2X;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX);
  localparam int unsigned BIT_W   = $clog2(WORD_W);

  seq_st_e          st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] conv_last;
  logic [BIT_W-1:0] bit_q;
  logic             fresh_q;
  logic             spd_q;
  logic             por_busy;
  logic             clr;
  logic             sck_fall;
  logic             sh_load;
  logic             sh_shift;
  logic             sh_msb;
  logic             conv_end;

  conv_seq_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .brownout_i (brownout_i),
    .busy_o     (por_busy)
  );

  assign clr       = por_busy | brownout_i;
  assign conv_last = spd_q ? CNT_W'(CONV_2X - 1) : CNT_W'(CONV_1X - 1);
  assign conv_end  = (st_q == ST_CONV) && (cnt_q == conv_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_CONV;
      cnt_q   <= '0;
      bit_q   <= '0;
      fresh_q <= 1'b0;
      spd_q   <= 1'b0;
    end else if (clr) begin
      st_q    <= ST_CONV;
      cnt_q   <= '0;
      bit_q   <= '0;
      fresh_q <= 1'b0;
      spd_q   <= speed_2x_i;
    end else begin
      if (st_q != ST_CONV) spd_q <= speed_2x_i;
      unique case (st_q)
        ST_CONV: begin
          if (conv_end) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            fresh_q <= 1'b1;
            st_q    <= cs_ni ? ST_SLEEP : ST_OUT;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SLEEP: if (!cs_ni) st_q <= ST_OUT;
        ST_OUT: begin
          if (cs_ni) begin
            st_q    <= ST_CONV;
            fresh_q <= 1'b0;
            bit_q   <= '0;
          end else if (sck_fall) begin
            if (bit_q == BIT_W'(WORD_W - 1)) begin
              st_q    <= ST_CONV;
              fresh_q <= 1'b0;
              bit_q   <= '0;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_CONV;
      endcase
    end
  end

  conv_seq_sckgen #(.SCK_DIV(SCK_DIV)) u_sck (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (st_q == ST_OUT),
    .int_mode_i (sck_int_i),
    .sck_i      (sck_i),
    .sck_o      (sck_o),
    .fall_o     (sck_fall)
  );

  assign sh_load  = conv_end;
  assign sh_shift = (st_q == ST_OUT) && !cs_ni && sck_fall;

  conv_seq_shift #(.WORD_W(WORD_W)) u_sh (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .load_i  (sh_load),
    .data_i  (res_word_i),
    .shift_i (sh_shift),
    .msb_o   (sh_msb)
  );

  assign eoc_o = fresh_q;
  assign sdo_o = (st_q == ST_OUT) ? sh_msb : 1'b1;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk
  import conv_seq_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BIT_W  = 5,
  parameter int unsigned WORD_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             brownout_i,
  input logic             cs_ni,
  input logic             eoc_o,
  input logic             sdo_o,
  input logic             sck_o,
  input seq_st_e          st_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] last_i,
  input logic [BIT_W-1:0] bit_i,
  input logic             fall_i,
  input logic             por_busy_i
);
  AST_POR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_busy_i |-> !eoc_o); // R1
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_o) |-> ($past(cnt_i) == $past(last_i))); // R2
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_SLEEP && cs_ni && !brownout_i) |=> (st_i == ST_SLEEP && eoc_o)); // R3
  AST_SCK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> !sck_o); // R5
  AST_WORD_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OUT && !cs_ni && fall_i && bit_i == BIT_W'(WORD_W - 1) && !brownout_i)
    |=> (st_i == ST_CONV && !eoc_o)); // R6
  AST_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OUT && cs_ni && !brownout_i) |=> (st_i == ST_CONV && !eoc_o)); // R7
  AST_SDO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_o |-> sdo_o); // R8
endmodule

bind conv_seq_top conv_seq_chk #(
  .CNT_W  (CNT_W),
  .BIT_W  (BIT_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .brownout_i (brownout_i),
  .cs_ni      (cs_ni),
  .eoc_o      (eoc_o),
  .sdo_o      (sdo_o),
  .sck_o      (sck_o),
  .st_i       (st_q),
  .cnt_i      (cnt_q),
  .last_i     (conv_last),
  .bit_i      (bit_q),
  .fall_i     (sck_fall),
  .por_busy_i (por_busy)
);

// File: tb/sim_conv_seq_top.sv
module sim_conv_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int L1X = 37;
  localparam int L2X = 19;
  localparam int POR = 20;

  // [33] speed_2x, [32] internal sck, [31:0] result word
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b1, 32'hA5A5_0F0F},
    {1'b1, 1'b1, 32'h0123_4567},
    {1'b0, 1'b0, 32'hFFFF_0000},
    {1'b1, 1'b0, 32'h8421_7BDE}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        brownout_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic        sck_i = 1'b0;
  logic        sck_int_i = 1'b1;
  logic        speed_2x_i = 1'b0;
  logic [31:0] res_word_i = 32'h8000_0001;
  logic        eoc_o, sdo_o, sck_o;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  conv_seq_top #(
    .CONV_1X(L1X), .CONV_2X(L2X), .POR_CYCLES(POR), .WORD_W(32), .SCK_DIV(8)
  ) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .brownout_i(brownout_i), .cs_ni(cs_ni),
    .sck_i(sck_i), .sck_int_i(sck_int_i), .speed_2x_i(speed_2x_i),
    .res_word_i(res_word_i), .eoc_o(eoc_o), .sdo_o(sdo_o), .sck_o(sck_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // counts negedges until eoc_o rises, starting at a negedge
  task automatic wait_eoc(output int n);
    n = 0;
    while (!eoc_o && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic do_read(input bit ext, output logic [31:0] w, output int nbits,
                         output int bad_per);
    int t = 0;
    int last = -1;
    logic prev = 1'b0;
    w = '0; nbits = 0; bad_per = 0;
    cs_ni = 1'b0;
    if (!ext) begin
      while (t < 2000) begin
        @(negedge clk_i);
        t++;
        if (!eoc_o) break;
        if (sck_o && !prev) begin
          w = {w[30:0], sdo_o};
          nbits++;
          if (last >= 0 && t - last != 8) bad_per++;
          if (last < 0 && t != 5) bad_per++;
          last = t;
        end
        prev = sck_o;
      end
    end else begin
      for (int k = 0; k < 32; k++) begin
        repeat (3) @(negedge clk_i);
        w = {w[30:0], sdo_o};
        sck_i = 1'b1;
        repeat (4) @(negedge clk_i);
        sck_i = 1'b0;
        nbits++;
      end
      @(negedge clk_i);
    end
    cs_ni = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] prev_w;
    logic [31:0] got;
    int n, nb, bp, bad;

    repeat (3) @(negedge clk_i);
    chk(!eoc_o && sdo_o && !sck_o, "R9 reset outputs", {eoc_o, sdo_o, sck_o}, 3'b010);

    rst_ni = 1'b1;
    wait_eoc(n);
    chk(n == POR + L1X, "R1 por+conv after reset", n, POR + L1X);

    bad = 0;
    repeat (60) begin
      @(negedge clk_i);
      if (!eoc_o || !sdo_o || sck_o) bad++;
    end
    chk(bad == 0, "R3 sleep hold", bad, 0);

    prev_w = 32'h8000_0001;
    foreach (VEC[i]) begin
      speed_2x_i = VEC[i][33];
      sck_int_i  = VEC[i][32];
      res_word_i = VEC[i][31:0];
      do_read(!VEC[i][32], got, nb, bp);
      chk(got == prev_w, VEC[i][32] ? "R4 word internal sck" : "R10 word external sck",
          got, prev_w);
      if (VEC[i][32]) chk(nb == 32 && bp == 0, "R5 sck rises and period", {nb, bp}, {32'd32, 32'd0});
      chk(!eoc_o, "R6 eoc drops after 32 clocks", eoc_o, 0);
      wait_eoc(n);
      chk(n == (VEC[i][33] ? L2X : L1X), "R2 conversion length", n, VEC[i][33] ? L2X : L1X);
      prev_w = VEC[i][31:0];
    end

    // R8: select low through a whole conversion
    sck_int_i  = 1'b1;
    speed_2x_i = 1'b0;
    res_word_i = 32'h1357_9BDF;
    do_read(1'b0, got, nb, bp);
    chk(got == prev_w, "R4 word before low-select test", got, prev_w);
    cs_ni = 1'b0;
    bad = 0;
    n = 0;
    while (!eoc_o && n < 5000) begin
      if (!sdo_o) bad++;
      @(negedge clk_i);
      n++;
    end
    chk(bad == 0, "R8 sdo high while converting", bad, 0);
    res_word_i = 32'h2468_ACE0;
    do_read(1'b0, got, nb, bp);
    chk(got == 32'h1357_9BDF && nb == 32, "R8 direct readout", got, 32'h1357_9BDF);
    wait_eoc(n);

    // R7: abort after five bits
    res_word_i = 32'h0F0F_F0F0;
    cs_ni = 1'b0;
    nb = 0;
    begin
      logic p = 1'b0;
      while (nb < 5) begin
        @(negedge clk_i);
        if (sck_o && !p) nb++;
        p = sck_o;
      end
    end
    cs_ni = 1'b1;
    @(negedge clk_i);
    chk(!eoc_o && sdo_o, "R7 abort drops eoc", eoc_o, 0);
    wait_eoc(n);
    chk(n == L1X, "R7 conversion after abort", n, L1X);
    do_read(1'b0, got, nb, bp);
    chk(got == 32'h0F0F_F0F0, "R7 new result after abort", got, 32'h0F0F_F0F0);
    wait_eoc(n);

    // R1: brown-out during sleep
    res_word_i = 32'hC3C3_3C3C;
    brownout_i = 1'b1;
    @(negedge clk_i);
    brownout_i = 1'b0;
    chk(!eoc_o, "R1 brownout clears eoc", eoc_o, 0);
    wait_eoc(n);
    chk(n == POR + L1X, "R1 por+conv after brownout", n, POR + L1X);
    do_read(1'b0, got, nb, bp);
    chk(got == 32'hC3C3_3C3C, "R4 word after brownout", got, 32'hC3C3_3C3C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule